// File: doc/BRIEF.md
# Power-Good Delayed Reset Generator

This block produces an active-low reset for logic powered by a regulator. It watches a synchronous flag that says the regulated output lies inside its valid voltage band, with threshold hysteresis already applied upstream. It releases the reset only after that flag has been steady for a short qualification time and then for a longer hold-off delay. Both intervals are counted in clock cycles and set by parameters.

An active-high reset request from outside pulls the reset output low on the next clock edge, for as long as the request stays high. The request acts on the reset output only. When the request drops and the voltage band is still valid, the hold-off delay starts again from zero. If the band was lost in the meantime, the delay stays cleared until the band returns and has been qualified again. Losing the band, or dropping the enable, clears all timing on the next edge. A new release then needs the full qualification time plus the full delay.

Top module: `pwrgood_rst_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the edge after it is applied, `por_n_o` is low. After reset the qualification and delay timers are both cleared.
- R2: The window flag only counts as qualified after it has been sampled high on FILT_CYC consecutive edges. A high stretch shorter than that restarts qualification from zero and does not shorten a later release.
- R3: With `en` high and `rst_req_i` low, and `win_ok_i` held high from reset or from a cleared state, `por_n_o` goes high on exactly the (FILT_CYC+DELAY_CYC)-th edge that samples `win_ok_i` high. It is low before that edge.
- R4: An edge that samples `win_ok_i` low drives `por_n_o` low on that edge. It also clears both timers, so the next release again takes FILT_CYC+DELAY_CYC edges.
- R5: An edge that samples `rst_req_i` high drives `por_n_o` low on that edge, and `por_n_o` stays low on every edge that samples the request high.
- R6: When `rst_req_i` falls while the window stays valid and qualified, `por_n_o` goes high on exactly the DELAY_CYC-th edge that samples the request low. Qualification is not repeated.
- R7: When `rst_req_i` falls while `win_ok_i` is low, `por_n_o` stays low. Release comes FILT_CYC+DELAY_CYC edges after the window returns.
- R8: An edge that samples `en` low drives `por_n_o` low on that edge and clears both timers. After `en` rises with a valid window, release takes FILT_CYC+DELAY_CYC edges.
- R9: A reset request only one clock cycle wide is honoured. It drives `por_n_o` low and restarts the full DELAY_CYC count.
- R10: Once released, `por_n_o` stays high without glitches as long as `en` and `win_ok_i` are high and `rst_req_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Supervisor enable; low holds the reset output asserted |
| win_ok_i | input | 1 | Output voltage inside its power-good band (hysteresis applied upstream) |
| rst_req_i | input | 1 | Active-high external reset request |
| por_n_o | output | 1 | Active-low delayed power-on reset |

## Verification
The main release path is driven from three different starting points: a fresh power-up with the window steady, recovery after a reset request, and recovery after the window or the enable was lost. Each start point is checked one edge before and on the predicted release edge. This tells a qualification-plus-delay restart apart from a delay-only restart. A request that falls while the window is invalid shows that the window condition wins over the request's falling edge. A window high stretch shorter than the qualification time shows that the filter really restarts rather than accumulating. Single-cycle request pulses and a mid-run synchronous reset cover the narrowest stimuli.

// File: rtl/prg_pkg.sv
package prg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_HELD     = 3'd1,
        ST_WAIT     = 3'd2,
        ST_COUNT    = 3'd3,
        ST_RELEASED = 3'd4
    } prg_state_e;

    typedef struct packed {
        logic enabled;
        logic request;
        logic win_now;
        logic win_qual;
    } prg_cond_t;

    function automatic int prg_width(input int unsigned limit);
        int w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/prg_window_filter.sv
module prg_window_filter
    import prg_pkg::*;
#(
    parameter int unsigned FILT_CYC = 812
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic win_raw,
    output logic win_qual
);
    localparam int CW = prg_width(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          qual_q;

    always_ff @(posedge clk) begin
        if (rst || !en || !win_raw) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else if (!qual_q) begin
            if (cnt_q == LAST) begin
                qual_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign win_qual = qual_q;
endmodule

// File: rtl/prg_delay_timer.sv
module prg_delay_timer
    import prg_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int CW = prg_width(DELAY_CYC);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);
endmodule

// File: rtl/pwrgood_rst_gen.sv
module pwrgood_rst_gen
    import prg_pkg::*;
#(
    parameter int unsigned FILT_CYC  = 812,
    parameter int unsigned DELAY_CYC = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic win_ok_i,
    input  logic rst_req_i,
    output logic por_n_o
);
    prg_state_e state_q;
    prg_state_e state_d;
    prg_cond_t  cond;
    logic       win_qual;
    logic       delay_done;
    logic       tmr_clr;

    prg_window_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .win_raw  (win_ok_i),
        .win_qual (win_qual)
    );

    always_comb begin
        cond.enabled  = en;
        cond.request  = rst_req_i;
        cond.win_now  = win_ok_i;
        cond.win_qual = win_qual;
    end

    // Priority: enable, then request, then window, then timing.
    always_comb begin
        if (!cond.enabled) begin
            state_d = ST_IDLE;
        end else if (cond.request) begin
            state_d = ST_HELD;
        end else if (!cond.win_now || !cond.win_qual) begin
            state_d = ST_WAIT;
        end else if (state_q == ST_RELEASED || delay_done) begin
            state_d = ST_RELEASED;
        end else begin
            state_d = ST_COUNT;
        end
    end

    assign tmr_clr = (state_d != ST_COUNT);

    prg_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .inc  (1'b1),
        .done (delay_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign por_n_o = (state_q == ST_RELEASED);
endmodule

// File: rtl/pwrgood_rst_gen_chk.sv
module pwrgood_rst_gen_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic win_ok_i,
    input logic rst_req_i,
    input logic por_n_o
);
    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !por_n_o);

    // R4
    window_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !win_ok_i |=> !por_n_o);

    // R5
    request_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_i |=> !por_n_o);

    // R8
    enable_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !por_n_o);

    // R10
    release_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (por_n_o && en && win_ok_i && !rst_req_i) |=> por_n_o);

    // R3
    release_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(por_n_o) |-> $past(en && win_ok_i && !rst_req_i));
endmodule

bind pwrgood_rst_gen pwrgood_rst_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .win_ok_i  (win_ok_i),
    .rst_req_i (rst_req_i),
    .por_n_o   (por_n_o)
);

// File: tb/pwrgood_rst_gen_tb.sv
module pwrgood_rst_gen_tb;
    localparam int unsigned F = 4;
    localparam int unsigned D = 20;
    localparam int FD = F + D;
    localparam int NV = 27;

    // vector: {tag[3:0], en, win, req, edges[7:0], expected}
    function automatic logic [15:0] mk(input int tag, input logic e, input logic w,
                                       input logic r, input int n, input logic x);
        return {4'(tag), e, w, r, 8'(n), x};
    endfunction

    localparam logic [15:0] VEC [NV] = '{
        mk(3, 1, 1, 0, FD-1, 0),   // R3 one edge early
        mk(3, 1, 1, 0, 1,    1),   // R3 release edge
        mk(5, 1, 1, 1, 1,    0),   // R5 immediate
        mk(5, 1, 1, 1, 5,    0),   // R5 held
        mk(6, 1, 1, 0, D-1,  0),   // R6 one early
        mk(6, 1, 1, 0, 1,    1),   // R6 release
        mk(4, 1, 0, 0, 1,    0),   // R4 immediate
        mk(4, 1, 1, 0, FD-1, 0),   // R4 full restart
        mk(4, 1, 1, 0, 1,    1),
        mk(8, 0, 1, 0, 1,    0),   // R8 immediate
        mk(8, 1, 1, 0, FD-1, 0),   // R8 full restart
        mk(8, 1, 1, 0, 1,    1),
        mk(7, 1, 1, 1, 2,    0),   // R7 request high
        mk(7, 1, 0, 0, 10,   0),   // R7 request falls, window gone
        mk(7, 1, 1, 0, FD-1, 0),
        mk(7, 1, 1, 0, 1,    1),
        mk(2, 1, 0, 0, 1,    0),   // R2 window lost
        mk(2, 1, 1, 0, F-1,  0),   // R2 short stretch
        mk(2, 1, 0, 0, 1,    0),
        mk(2, 1, 1, 0, FD-1, 0),   // R2 no credit from short stretch
        mk(2, 1, 1, 0, 1,    1),
        mk(9, 1, 1, 1, 1,    0),   // R9 single-cycle request
        mk(9, 1, 1, 0, D-1,  0),
        mk(9, 1, 1, 0, 1,    1),
        mk(10, 1, 1, 0, 30,  1),   // R10 stays released
        mk(9, 1, 1, 1, 1,    0),   // R9 second narrow pulse
        mk(9, 1, 1, 0, D,    1)
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic win_ok_i = 1'b0;
    logic rst_req_i = 1'b0;
    logic por_n_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwrgood_rst_gen #(.FILT_CYC(F), .DELAY_CYC(D)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .win_ok_i  (win_ok_i),
        .rst_req_i (rst_req_i),
        .por_n_o   (por_n_o)
    );

    task automatic check(input int tag, input logic expv, input string what);
        checks++;
        if (por_n_o !== expv) begin
            failures++;
            $display("FAIL R%0d %s: por_n_o=%b expected=%b", tag, what, por_n_o, expv);
        end
    endtask

    task automatic apply(input logic e, input logic w, input logic r, input int n);
        @(negedge clk);
        en = e;
        win_ok_i = w;
        rst_req_i = r;
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        // R1: output low under reset
        repeat (3) @(posedge clk);
        #2;
        check(1, 1'b0, "during reset");
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][11], VEC[i][10], VEC[i][9], int'(VEC[i][8:1]));
            check(int'(VEC[i][15:12]), VEC[i][0], $sformatf("vector %0d", i));
        end

        // R1: reset while released, then full restart afterwards
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check(1, 1'b0, "mid-run reset");
        @(negedge clk);
        rst = 1'b0;
        repeat (FD - 1) @(posedge clk);
        #2;
        check(3, 1'b0, "after reset, one early");
        @(posedge clk);
        #2;
        check(3, 1'b1, "after reset, release");

        // R5 and R4 together: request and window loss at once
        apply(1, 0, 1, 1);
        check(5, 1'b0, "request with window loss");
        apply(1, 1, 0, FD - 1);
        check(7, 1'b0, "window back, one early");
        apply(1, 1, 0, 1);
        check(7, 1'b1, "window back, release");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule